// File: doc/BRIEF.md
# ATA Task-File Address and Count Latch

This block holds the address-bearing part of an ATA task file for one channel that serves two drives. A host register interface writes single bytes to the sector-count, sector-number, cylinder-low, cylinder-high and device/head offsets. The block decodes the addressing mode from the device/head byte and presents, for each drive, a 48-bit block address and a 16-bit sector count that are already formed for that mode. It also presents the same pair for the drive that device/head currently selects.

In the legacy modes (CHS and 28-bit LBA) the four byte registers are shared by both drives and make up the address directly. In 48-bit mode every address and count offset is written twice. The first write of a pair fills the high-order byte of its field and the second write fills the low-order byte. Each field has its own per-drive toggle that tracks which half comes next. A change of the mode bits in device/head re-arms all toggles. A command-issue strobe clears the accumulated 48-bit state of the selected drive so that the next command starts clean.

Top module: `ata_lba_latch`

## Requirements
- R1: `mode_o` is decoded from device/head as follows. Bit 6 clear gives 0 (CHS). Bit 6 set with bits 7 and 5 both set gives 1 (28-bit LBA). Bit 6 set with bits 7 and 5 both clear gives 2 (48-bit LBA). Bit 6 set with bits 7 and 5 differing gives 3 (mixed), which forms its outputs as in 28-bit mode.
- R2: Register offsets on `wr_addr_i` are 2 for sector count, 3 for sector number, 4 for cylinder low, 5 for cylinder high and 6 for device/head. Writes to offsets 0, 1 and 7 change no output.
- R3: Every write to offsets 2 to 5 updates that byte register in any mode. In modes 0, 1 and 3 each drive's address is {zeros, device/head[3:0], cylinder high, cylinder low, sector number}, and its count is the sector-count byte.
- R4: In modes 0, 1 and 3 a sector-count byte of zero yields a count of 256.
- R5: In mode 2, the first sector-count write of a pair sets count[15:8] to the data and count[7:0] to zero. The second write ORs the data into count[7:0].
- R6: In mode 2, the first and second writes are ORed into these address bits: sector number into [31:24] then [7:0], cylinder low into [39:32] then [15:8], cylinder high into [47:40] then [23:16].
- R7: Each of the four fields keeps its own first/second toggle, so writes to one field do not advance another.
- R8: A device/head write whose bits 7:5 differ from the held value resets every toggle of both drives to "first". A device/head write with the same bits 7:5 leaves the toggles as they are, and no device/head write changes the accumulated values.
- R9: `cmd_issue_i` clears the accumulated address, count and toggles of the drive selected by device/head bit 4 only. A write in the same cycle does not reach the drive being cleared.
- R10: A mode-2 write updates the accumulators and toggles of both drives in the same cycle.
- R11: `drv_sel_o` equals device/head bit 4, and `sel_lba_o` / `sel_count_o` carry the outputs of that drive.
- R12: After reset every register is zero, so the mode is CHS, both addresses are zero and both counts are 256.
- R13: Writes made in modes 0, 1 or 3 leave the 48-bit accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Task-file register offset |
| wr_data_i | input | 8 | Write data byte |
| cmd_issue_i | input | 1 | Command issued; clears the selected drive's 48-bit state |
| mode_o | output | 2 | Decoded addressing mode |
| drv_sel_o | output | 1 | Selected drive |
| lba_o | output | 96 | Drive d address at [48*d+47 : 48*d] |
| count_o | output | 32 | Drive d sector count at [16*d+15 : 16*d] |
| sel_lba_o | output | 48 | Address of the selected drive |
| sel_count_o | output | 16 | Sector count of the selected drive |

## Verification
All state sits in registers that are loaded on the write edge, and every output is a combinational function of those registers. A write, a command strobe or a device/head change therefore shows its effect on the outputs exactly one clock edge later. Each bench task drives its inputs on a falling edge and releases them on the next falling edge, after the loading rising edge has passed. The checks then sample at that falling edge, where the result is due. The double-pumped sequences are checked after each half, so the result of a misrouted byte or a toggle that failed to advance or re-arm shows up in the cycle that caused it.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int NUM_DRV = 2;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int LBA_W   = 48;
  localparam int CNT_W   = 16;
  localparam int NUM_FLD = 4;
  localparam int FLD_W   = 2 * BYTE_W;
  localparam int L28_W   = 28;

  typedef enum logic [1:0] {
    MODE_CHS   = 2'd0,
    MODE_LBA28 = 2'd1,
    MODE_LBA48 = 2'd2,
    MODE_MIXED = 2'd3
  } addr_mode_e;

  localparam logic [ADDR_W-1:0] OFS_COUNT    = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_SECT     = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CYL_LO   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CYL_HI   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_DEV_HEAD = 3'd6;

  // field index order inside a drive accumulator
  localparam int FLD_COUNT  = 0;
  localparam int FLD_SECT   = 1;
  localparam int FLD_CYL_LO = 2;
  localparam int FLD_CYL_HI = 3;
endpackage

// File: rtl/ata_mode_decode.sv
module ata_mode_decode
  import ata_tf_pkg::*;
(
  input  logic [BYTE_W-1:0] dev_head_i,
  output addr_mode_e        mode_o
);
  always_comb begin
    if (!dev_head_i[6])                         mode_o = MODE_CHS;
    else if (dev_head_i[7] && dev_head_i[5])    mode_o = MODE_LBA28;
    else if (!dev_head_i[7] && !dev_head_i[5])  mode_o = MODE_LBA48;
    else                                        mode_o = MODE_MIXED;
  end
endmodule

// File: rtl/ata_acc_field.sv
module ata_acc_field
  import ata_tf_pkg::*;
#(
  parameter bit LOAD_FIRST = 1'b0  // first write replaces the field instead of ORing
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              rearm_i,
  input  logic              clr_i,
  output logic [FLD_W-1:0]  val_o,
  output logic              tog_o
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      tog_q <= 1'b0;
    end else if (clr_i) begin
      hi_q  <= '0;
      lo_q  <= '0;
      tog_q <= 1'b0;
    end else if (rearm_i) begin
      tog_q <= 1'b0;
    end else if (wr_i) begin
      if (!tog_q) begin
        if (LOAD_FIRST) begin
          hi_q <= data_i;
          lo_q <= '0;
        end else begin
          hi_q <= hi_q | data_i;
        end
      end else begin
        lo_q <= lo_q | data_i;
      end
      tog_q <= ~tog_q;
    end
  end

  assign val_o = {hi_q, lo_q};
  assign tog_o = tog_q;
endmodule

// File: rtl/ata_drive_acc.sv
module ata_drive_acc
  import ata_tf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FLD-1:0] wr_fld_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic               rearm_i,
  input  logic               clr_i,
  output logic [LBA_W-1:0]   lba_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [NUM_FLD-1:0] tog_o
);
  logic [NUM_FLD-1:0][FLD_W-1:0] fld_val;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    ata_acc_field #(.LOAD_FIRST(f == FLD_COUNT)) u_fld (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_fld_i[f]),
      .data_i  (data_i),
      .rearm_i (rearm_i),
      .clr_i   (clr_i),
      .val_o   (fld_val[f]),
      .tog_o   (tog_o[f])
    );
  end

  // high halves fill bits 47:24, low halves fill bits 23:0
  assign lba_o = {fld_val[FLD_CYL_HI][FLD_W-1:BYTE_W],
                  fld_val[FLD_CYL_LO][FLD_W-1:BYTE_W],
                  fld_val[FLD_SECT][FLD_W-1:BYTE_W],
                  fld_val[FLD_CYL_HI][BYTE_W-1:0],
                  fld_val[FLD_CYL_LO][BYTE_W-1:0],
                  fld_val[FLD_SECT][BYTE_W-1:0]};
  assign cnt_o = fld_val[FLD_COUNT];
endmodule

// File: rtl/ata_lba_latch.sv
module ata_lba_latch
  import ata_tf_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic                       cmd_issue_i,
  output logic [1:0]                 mode_o,
  output logic                       drv_sel_o,
  output logic [NUM_DRV*LBA_W-1:0]   lba_o,
  output logic [NUM_DRV*CNT_W-1:0]   count_o,
  output logic [LBA_W-1:0]           sel_lba_o,
  output logic [CNT_W-1:0]           sel_count_o
);
  localparam int LBA_PAD = LBA_W - L28_W;

  logic [BYTE_W-1:0] cnt_q, sect_q, cyl_lo_q, cyl_hi_q, dh_q;
  addr_mode_e        mode;
  logic              is_l48;
  logic              rearm;
  logic [NUM_FLD-1:0]         wr_fld;
  logic [LBA_W-1:0]           lba_legacy;
  logic [CNT_W-1:0]           cnt_legacy;
  logic [NUM_DRV*LBA_W-1:0]   acc_lba;
  logic [NUM_DRV*CNT_W-1:0]   acc_cnt;
  logic [NUM_DRV*NUM_FLD-1:0] acc_tog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sect_q   <= '0;
      cyl_lo_q <= '0;
      cyl_hi_q <= '0;
      dh_q     <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        OFS_COUNT:    cnt_q    <= wr_data_i;
        OFS_SECT:     sect_q   <= wr_data_i;
        OFS_CYL_LO:   cyl_lo_q <= wr_data_i;
        OFS_CYL_HI:   cyl_hi_q <= wr_data_i;
        OFS_DEV_HEAD: dh_q     <= wr_data_i;
        default: ;
      endcase
    end
  end

  ata_mode_decode u_dec (
    .dev_head_i (dh_q),
    .mode_o     (mode)
  );

  assign is_l48 = (mode == MODE_LBA48);
  assign rearm  = wr_en_i && (wr_addr_i == OFS_DEV_HEAD) && (wr_data_i[7:5] != dh_q[7:5]);

  always_comb begin
    wr_fld = '0;
    if (wr_en_i && is_l48) begin
      wr_fld[FLD_COUNT]  = (wr_addr_i == OFS_COUNT);
      wr_fld[FLD_SECT]   = (wr_addr_i == OFS_SECT);
      wr_fld[FLD_CYL_LO] = (wr_addr_i == OFS_CYL_LO);
      wr_fld[FLD_CYL_HI] = (wr_addr_i == OFS_CYL_HI);
    end
  end

  assign lba_legacy = {{LBA_PAD{1'b0}}, dh_q[3:0], cyl_hi_q, cyl_lo_q, sect_q};
  assign cnt_legacy = (cnt_q == '0) ? CNT_W'(256) : CNT_W'(cnt_q);

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    ata_drive_acc u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_fld_i (wr_fld),
      .data_i   (wr_data_i),
      .rearm_i  (rearm),
      .clr_i    (cmd_issue_i && (dh_q[4] == 1'(d))),
      .lba_o    (acc_lba[d*LBA_W +: LBA_W]),
      .cnt_o    (acc_cnt[d*CNT_W +: CNT_W]),
      .tog_o    (acc_tog[d*NUM_FLD +: NUM_FLD])
    );
    assign lba_o[d*LBA_W +: LBA_W]   = is_l48 ? acc_lba[d*LBA_W +: LBA_W] : lba_legacy;
    assign count_o[d*CNT_W +: CNT_W] = is_l48 ? acc_cnt[d*CNT_W +: CNT_W] : cnt_legacy;
  end

  assign mode_o      = mode;
  assign drv_sel_o   = dh_q[4];
  assign sel_lba_o   = dh_q[4] ? lba_o[LBA_W +: LBA_W]   : lba_o[0 +: LBA_W];
  assign sel_count_o = dh_q[4] ? count_o[CNT_W +: CNT_W] : count_o[0 +: CNT_W];
endmodule

// File: rtl/ata_lba_latch_chk.sv
module ata_lba_latch_chk
  import ata_tf_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [BYTE_W-1:0]          wr_data_i,
  input logic                       cmd_issue_i,
  input logic [1:0]                 mode_o,
  input logic [NUM_DRV*CNT_W-1:0]   count_o,
  input logic [BYTE_W-1:0]          dh_q,
  input logic [BYTE_W-1:0]          cnt_q,
  input logic [NUM_DRV*LBA_W-1:0]   acc_lba,
  input logic [NUM_DRV*CNT_W-1:0]   acc_cnt,
  input logic [NUM_DRV*NUM_FLD-1:0] acc_tog
);
  // R3
  count_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == OFS_COUNT |=> cnt_q == $past(wr_data_i));

  // R4
  legacy_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'(MODE_LBA48) |-> count_o[CNT_W-1:0] != '0 && count_o[2*CNT_W-1:CNT_W] != '0);

  // R8
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == OFS_DEV_HEAD && wr_data_i[7:5] != dh_q[7:5] |=> acc_tog == '0);

  // R9
  clear_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue_i && !dh_q[4] |=> acc_lba[LBA_W-1:0] == '0 && acc_cnt[CNT_W-1:0] == '0);

  // R9
  other_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_issue_i && !dh_q[4] && !wr_en_i |=>
      $stable(acc_lba[2*LBA_W-1:LBA_W]) && $stable(acc_cnt[2*CNT_W-1:CNT_W]));

  // R13
  legacy_no_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && mode_o != 2'(MODE_LBA48) && !cmd_issue_i |=> $stable(acc_lba) && $stable(acc_cnt));
endmodule

bind ata_lba_latch ata_lba_latch_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .cmd_issue_i (cmd_issue_i),
  .mode_o      (mode_o),
  .count_o     (count_o),
  .dh_q        (dh_q),
  .cnt_q       (cnt_q),
  .acc_lba     (acc_lba),
  .acc_cnt     (acc_cnt),
  .acc_tog     (acc_tog)
);

// File: tb/ata_lba_latch_test.sv
module ata_lba_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cmd = 1'b0;
  logic [1:0]  mode;
  logic        drv_sel;
  logic [95:0] lba;
  logic [31:0] count;
  logic [47:0] sel_lba;
  logic [15:0] sel_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_lba_latch uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .cmd_issue_i (cmd),
    .mode_o      (mode),
    .drv_sel_o   (drv_sel),
    .lba_o       (lba),
    .count_o     (count),
    .sel_lba_o   (sel_lba),
    .sel_count_o (sel_count)
  );

  wire [47:0] lba0 = lba[47:0];
  wire [47:0] lba1 = lba[95:48];
  wire [15:0] cnt0 = count[15:0];
  wire [15:0] cnt1 = count[31:16];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue();
    @(negedge clk);
    cmd = 1'b1;
    @(negedge clk);
    cmd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R12 mode", 64'(mode), 64'd0);
    chk("R12 lba0", 64'(lba0), 64'd0);
    chk("R12 lba1", 64'(lba1), 64'd0);
    chk("R12 cnt0", 64'(cnt0), 64'd256);
    chk("R12 cnt1", 64'(cnt1), 64'd256);
  endtask

  task automatic t_legacy();
    wr(3'd6, 8'hE5);
    chk("R1 lba28 mode", 64'(mode), 64'd1);
    wr(3'd2, 8'h05); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33);
    chk("R3 lba0", 64'(lba0), 64'h0533_2211);
    chk("R3 lba1", 64'(lba1), 64'h0533_2211);
    chk("R3 cnt0", 64'(cnt0), 64'd5);
    wr(3'd7, 8'hFF); wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    chk("R2 ignored lba0", 64'(lba0), 64'h0533_2211);
    chk("R2 ignored cnt0", 64'(cnt0), 64'd5);
    chk("R2 ignored mode", 64'(mode), 64'd1);
    wr(3'd6, 8'h05);
    chk("R1 chs mode", 64'(mode), 64'd0);
    chk("R3 chs lba0", 64'(lba0), 64'h0533_2211);
    wr(3'd6, 8'hC0);
    chk("R1 mixed mode", 64'(mode), 64'd3);
    chk("R1 mixed lba0", 64'(lba0), 64'h0033_2211);
  endtask

  task automatic t_zero();
    wr(3'd6, 8'hE0);
    wr(3'd2, 8'h00);
    chk("R4 cnt0", 64'(cnt0), 64'd256);
    chk("R4 cnt1", 64'(cnt1), 64'd256);
    wr(3'd2, 8'h01);
    chk("R4 one", 64'(cnt0), 64'd1);
  endtask

  task automatic t_noleak();
    wr(3'd6, 8'h40);
    chk("R1 lba48 mode", 64'(mode), 64'd2);
    chk("R13 lba0", 64'(lba0), 64'd0);
    chk("R13 lba1", 64'(lba1), 64'd0);
    chk("R13 cnt0", 64'(cnt0), 64'd0);
  endtask

  task automatic t_l48();
    wr(3'd2, 8'h12);
    chk("R5 first half", 64'(cnt0), 64'h1200);
    wr(3'd2, 8'h34);
    chk("R5 cnt0", 64'(cnt0), 64'h1234);
    chk("R10 cnt1", 64'(cnt1), 64'h1234);
    wr(3'd3, 8'hA1); wr(3'd3, 8'hA2);
    wr(3'd4, 8'hB1); wr(3'd4, 8'hB2);
    wr(3'd5, 8'hC1); wr(3'd5, 8'hC2);
    chk("R6 lba0", 64'(lba0), 64'hC1B1_A1C2_B2A2);
    chk("R10 lba1", 64'(lba1), 64'hC1B1_A1C2_B2A2);
    chk("R11 sel lba", 64'(sel_lba), 64'hC1B1_A1C2_B2A2);
  endtask

  task automatic t_indep();
    issue();
    chk("R9 cleared lba0", 64'(lba0), 64'd0);
    chk("R9 cleared cnt0", 64'(cnt0), 64'd0);
    chk("R9 kept lba1", 64'(lba1), 64'hC1B1_A1C2_B2A2);
    wr(3'd3, 8'h01); wr(3'd4, 8'h02); wr(3'd3, 8'h03);
    chk("R7 lba0", 64'(lba0), 64'h0002_0100_0003);
    chk("R6 or lba1", 64'(lba1), 64'hC1B3_A1C2_B2A3);
  endtask

  task automatic t_rearm();
    issue();
    wr(3'd2, 8'hAA);
    chk("R5 load hi", 64'(cnt0), 64'hAA00);
    wr(3'd6, 8'h40);
    wr(3'd2, 8'h0F);
    chk("R8 same bits keep", 64'(cnt0), 64'hAA0F);
    wr(3'd2, 8'h11);
    wr(3'd6, 8'hE0);
    chk("R3 copy in l48", 64'(cnt0), 64'h0011);
    wr(3'd6, 8'h40);
    chk("R8 acc kept", 64'(cnt0), 64'h1100);
    wr(3'd2, 8'h22);
    chk("R8 rearmed", 64'(cnt0), 64'h2200);
  endtask

  task automatic t_cmd_sim();
    wr(3'd6, 8'h50);
    chk("R11 drv_sel", 64'(drv_sel), 64'd1);
    chk("R11 sel count", 64'(sel_count), 64'h2200);
    @(negedge clk);
    cmd = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h55;
    @(negedge clk);
    cmd = 1'b0; wr_en = 1'b0;
    chk("R9 clear wins cnt1", 64'(cnt1), 64'd0);
    chk("R9 other gets write", 64'(cnt0), 64'h2255);
    wr(3'd2, 8'h66);
    chk("R9 after clear cnt1", 64'(cnt1), 64'h6600);
    chk("R11 sel lba", 64'(sel_lba), 64'(lba1));
    chk("R11 sel count2", 64'(sel_count), 64'h6600);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy();
    t_zero();
    t_noleak();
    t_l48();
    t_indep();
    t_rearm();
    t_cmd_sim();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule